// File: doc/BRIEF.md
# Sleep-Mode Input Change Wake Detector

This block keeps watch over a wide group of input lines while the rest of a low-power device is asleep. The lines arrive as three vectors that the block joins into one word. When sleep is requested, the block stores the current word as a reference and enters its sleep state. From then on, a comparator checks every bit of the live word against that reference. The first mismatch ends the sleep state and inverts a wake toggle line. A downstream domain notices the wake by seeing that line change level.

Detection is a full bitwise inequality against the stored reference. An OR over the inputs would not work, because most lines sit high at rest. The mismatch flag comes from combinational logic, so it can signal a difference even with no clock edge. The comparator can be built flat or as a tree of segments, and a parameter picks which. Taking a new reference at sleep entry absorbs any change that happened before it, so no false wake is raised.

Top module: `wake_detector`

## Requirements
- R1: The monitored word is the concatenation {vec_c, vec_b, vec_a}, 66 bits with the default widths. Bit 0 of vec_a is word bit 0 and the top bit of vec_c is word bit 65.
- R2: change_o is high exactly when the live word differs from the stored reference in any bit. It follows the inputs in the same cycle, with no clock edge needed.
- R3: Detection uses inequality, not an OR of the inputs. With all inputs high and a reference of all ones, change_o is low.
- R4: When sleep_req is high at a clock edge, the reference takes the word present at that edge. asleep_o is high from that edge on.
- R5: While asleep_o is high, change_o is high and sleep_req is low at an edge, that edge clears asleep_o and inverts wake_tgl_o once.
- R6: While asleep_o is low, wake_tgl_o holds its value whatever the inputs do. A further toggle needs a new sleep entry.
- R7: sleep_req has priority over a wake in the same cycle. The reference absorbs the difference, asleep_o stays high and wake_tgl_o does not change.
- R8: When rst_n is low, asleep_o is 0, wake_tgl_o is 0 and the reference is all zeros.
- R9: While asleep_o is high and the inputs match the reference, asleep_o stays high and wake_tgl_o holds for any number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_req | input | 1 | Sleep-entry strobe; takes the reference |
| vec_a | input | 22 | Monitored lines, low part of the word |
| vec_b | input | 22 | Monitored lines, middle part of the word |
| vec_c | input | 22 | Monitored lines, high part of the word |
| change_o | output | 1 | Live word differs from the reference |
| wake_tgl_o | output | 1 | Inverts once for each wake event |
| asleep_o | output | 1 | High while in the sleep state |

## Verification
A sleep entry and a wake can fall on the same edge. This happens when the block is already asleep, one input bit flips, and sleep_req is pulsed in that same cycle. The bench sets up this case and then checks three things after the edge. asleep_o must still be high, wake_tgl_o must be unchanged, and change_o must be low, which shows that the new reference took in the flipped bit. The bench also flips single bits at both ends of the word and in its middle, to confirm the concatenation order and that every bit is compared.

// File: rtl/wd_pkg.sv
package wd_pkg;
   typedef enum logic {
      ST_AWAKE  = 1'b0,
      ST_ASLEEP = 1'b1
   } wd_state_e;
endpackage

// File: rtl/wd_snap.sv
module wd_snap #(
   parameter int W = 66
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] din,
   output logic [W-1:0] snap_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         snap_q <= '0;
      else if (load)
         snap_q <= din;
   end
endmodule

// File: rtl/wd_cmp.sv
module wd_cmp #(
   parameter int W        = 66,
   parameter int SEG_W    = 11,
   parameter bit FLAT_CMP = 1'b0
) (
   input  logic [W-1:0] live,
   input  logic [W-1:0] ref_w,
   output logic         diff
);
   localparam int NSEG = (W + SEG_W - 1) / SEG_W;

   generate
      if (FLAT_CMP) begin : g_flat
         assign diff = (live != ref_w);
      end else begin : g_tree
         logic [NSEG-1:0] seg_diff;
         for (genvar g = 0; g < NSEG; g++) begin : g_seg
            localparam int LO = g * SEG_W;
            localparam int HI = ((LO + SEG_W) > W) ? (W - 1) : (LO + SEG_W - 1);
            assign seg_diff[g] = |(live[HI:LO] ^ ref_w[HI:LO]);
         end
         assign diff = |seg_diff;
      end
   endgenerate
endmodule

// File: rtl/wd_ctrl.sv
module wd_ctrl
   import wd_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic sleep_req,
   input  logic change,
   output logic load_snap,
   output logic asleep,
   output logic wake_tgl
);
   wd_state_e state_q, state_d;
   logic      tgl_q, tgl_d;

   always_comb begin
      state_d   = state_q;
      tgl_d     = tgl_q;
      load_snap = 1'b0;
      if (sleep_req) begin
         load_snap = 1'b1;
         state_d   = ST_ASLEEP;
      end else if (state_q == ST_ASLEEP && change) begin
         state_d = ST_AWAKE;
         tgl_d   = ~tgl_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_AWAKE;
         tgl_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         tgl_q   <= tgl_d;
      end
   end

   assign asleep   = (state_q == ST_ASLEEP);
   assign wake_tgl = tgl_q;
endmodule

// File: rtl/wake_detector.sv
module wake_detector #(
   parameter int A_W      = 22,
   parameter int B_W      = 22,
   parameter int C_W      = 22,
   parameter int SEG_W    = 11,
   parameter bit FLAT_CMP = 1'b0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           sleep_req,
   input  logic [A_W-1:0] vec_a,
   input  logic [B_W-1:0] vec_b,
   input  logic [C_W-1:0] vec_c,
   output logic           change_o,
   output logic           wake_tgl_o,
   output logic           asleep_o
);
   localparam int W = A_W + B_W + C_W;

   generate
      if (A_W < 1 || B_W < 1 || C_W < 1) begin : g_bad_width
         $error("wake_detector: every vector width must be at least 1");
      end
      if (SEG_W < 1 || SEG_W > W) begin : g_bad_seg
         $error("wake_detector: SEG_W must lie between 1 and the word width");
      end
   endgenerate

   logic [W-1:0] word;
   logic [W-1:0] snap;
   logic         load_snap;

   assign word = {vec_c, vec_b, vec_a};

   wd_snap #(.W(W)) u_snap (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load_snap),
      .din    (word),
      .snap_q (snap)
   );

   wd_cmp #(.W(W), .SEG_W(SEG_W), .FLAT_CMP(FLAT_CMP)) u_cmp (
      .live  (word),
      .ref_w (snap),
      .diff  (change_o)
   );

   wd_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .sleep_req (sleep_req),
      .change    (change_o),
      .load_snap (load_snap),
      .asleep    (asleep_o),
      .wake_tgl  (wake_tgl_o)
   );
endmodule

// File: rtl/wd_wake_chk.sv
module wd_wake_chk #(
   parameter int W = 66
) (
   input logic         clk,
   input logic         rst_n,
   input logic         sleep_req,
   input logic [W-1:0] word,
   input logic         change,
   input logic         asleep,
   input logic         wake_tgl
);
   // R8: reset holds the control state cleared
   a_r8_reset_clear: assert property (@(posedge clk)
      !rst_n |-> (!asleep && !wake_tgl));

   // R4: sleep entry reaches the sleep state on the next cycle
   a_r4_sleep_entry: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_req |=> asleep);

   // R4, R7: after a sleep entry, unchanged inputs match the new reference
   a_r7_snapshot_absorbs: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_req |=> (!$stable(word) || !change));

   // R5: a detected difference while asleep wakes and toggles once
   a_r5_wake_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      (asleep && change && !sleep_req) |=> (!asleep && (wake_tgl != $past(wake_tgl))));

   // R6, R7, R9: the toggle moves only on a wake
   a_r6_toggle_only_on_wake: assert property (@(posedge clk) disable iff (!rst_n)
      !(asleep && change && !sleep_req) |=> $stable(wake_tgl));

   // R9: a quiet sleep persists
   a_r9_stay_asleep: assert property (@(posedge clk) disable iff (!rst_n)
      (asleep && !change) |=> asleep);
endmodule

bind wake_detector wd_wake_chk #(.W(W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sleep_req (sleep_req),
   .word      (word),
   .change    (change_o),
   .asleep    (asleep_o),
   .wake_tgl  (wake_tgl_o)
);

// File: tb/sim_wake_detector.sv
module sim_wake_detector;
   localparam int AW = 22, BW = 22, CW = 22;
   localparam int W  = AW + BW + CW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b1;
   logic          sleep_req = 1'b0;
   logic [W-1:0]  w = '1;
   logic          change_o, wake_tgl_o, asleep_o;
   logic          exp_tgl = 1'b0;
   int            n_chk = 0;
   int            n_err = 0;

   always #10 clk = ~clk;

   wake_detector u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .sleep_req  (sleep_req),
      .vec_a      (w[AW-1:0]),
      .vec_b      (w[AW+BW-1:AW]),
      .vec_c      (w[W-1:AW+BW]),
      .change_o   (change_o),
      .wake_tgl_o (wake_tgl_o),
      .asleep_o   (asleep_o)
   );

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic enter_sleep();
      @(negedge clk) sleep_req = 1'b1;
      @(negedge clk) sleep_req = 1'b0;
   endtask

   task automatic t_reset();
      @(negedge clk) rst_n = 1'b0;
      #5;
      chk("R8 asleep", W'(asleep_o), '0);
      chk("R8 toggle", W'(wake_tgl_o), '0);
      w = '0;
      #1 chk("R8 reference zero", W'(change_o), '0);
      w = '1;
      #1 chk("R2 all-ones vs zero reference", W'(change_o), 1);
      @(negedge clk) rst_n = 1'b1;
      exp_tgl = 1'b0;
   endtask

   task automatic t_sleep_quiet();
      w = '1;
      enter_sleep();
      chk("R4 asleep after entry", W'(asleep_o), 1);
      chk("R3 all-ones equal reference", W'(change_o), 0);
      for (int i = 0; i < 20; i++) @(negedge clk);
      chk("R9 stays asleep", W'(asleep_o), 1);
      chk("R9 toggle holds", W'(wake_tgl_o), W'(exp_tgl));
   endtask

   task automatic t_wake_bit(input int bitno, input string tag);
      @(negedge clk) w[bitno] = ~w[bitno];
      #1;
      chk({tag, " R2 change same cycle"}, W'(change_o), 1);
      chk({tag, " R5 still asleep before edge"}, W'(asleep_o), 1);
      @(negedge clk);
      exp_tgl = ~exp_tgl;
      chk({tag, " R5 awake"}, W'(asleep_o), 0);
      chk({tag, " R5 toggle"}, W'(wake_tgl_o), W'(exp_tgl));
   endtask

   task automatic t_awake_changes();
      @(negedge clk) w[30] = ~w[30];
      @(negedge clk) w[5] = ~w[5];
      for (int i = 0; i < 5; i++) @(negedge clk);
      chk("R6 toggle holds while awake", W'(wake_tgl_o), W'(exp_tgl));
      chk("R6 stays awake", W'(asleep_o), 0);
   endtask

   task automatic t_stale_diff_absorbed();
      // inputs differ from the old reference when sleep is requested
      w = {W{1'b1}} ^ (W'(1) << 40);
      #1 chk("R2 stale diff visible", W'(change_o), 1);
      enter_sleep();
      chk("R4 fresh reference absorbs", W'(change_o), 0);
      chk("R4 asleep", W'(asleep_o), 1);
      chk("R4 no spurious toggle", W'(wake_tgl_o), W'(exp_tgl));
   endtask

   task automatic t_collision();
      // already asleep; flip a bit and request sleep in the same cycle
      @(negedge clk) begin
         w[50] = ~w[50];
         sleep_req = 1'b1;
      end
      @(negedge clk) sleep_req = 1'b0;
      chk("R7 stays asleep", W'(asleep_o), 1);
      chk("R7 no toggle", W'(wake_tgl_o), W'(exp_tgl));
      chk("R7 reference absorbed", W'(change_o), 0);
   endtask

   task automatic t_reset_in_sleep();
      chk("R8 precondition asleep", W'(asleep_o), 1);
      t_reset();
   endtask

   initial begin
      #4_000_000;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      #1 rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_sleep_quiet();
      t_wake_bit(W-1, "R1 top bit");
      t_awake_changes();
      enter_sleep();
      chk("R4 re-entry", W'(asleep_o), 1);
      t_wake_bit(0, "R1 bit zero");
      enter_sleep();
      t_wake_bit(AW + 3, "R1 middle vector");
      t_stale_diff_absorbed();
      t_collision();
      t_wake_bit(17, "R5 after collision");
      enter_sleep();
      t_reset_in_sleep();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule